// File: doc/BRIEF.md
# Dual-Phase Sliding Code Correlator

This block finds a repeating 31-chip wakeup code in a one-bit on/off-keyed envelope stream. It never recovers symbol timing. Instead, the envelope is sampled twice per symbol, once at each edge of the symbol clock. Each edge arrives in the system clock domain as a single-cycle strobe. Every sample phase has its own sliding window of the most recent chips. After each shift, that window is scored against a programmable reference code.

Whenever a phase's agreement score reaches a programmable threshold, the block emits a one-cycle wakeup pulse. It also sets a sticky interrupt, which stays high until software clears it with a write-one control. A per-phase status field records which sample phase produced a detection. Clearing the enable empties both windows and suppresses detection. The envelope detector and the analog comparator sit outside the block.

Top module: `wake_corr_top`

## Requirements
- R1: Phase p (bit p of `phase_strobe`; bit 0 is the rising-edge phase, bit 1 the falling-edge phase) shifts its window only in a cycle where its own strobe is high. Both phases may shift in the same cycle, and a phase whose strobe is low keeps its window.
- R2: On a shift, `env_bit` enters window bit 0 and older chips move toward bit 30. A received code therefore lines up when the chip sent first matches `code[30]` and the chip sent last matches `code[0]`.
- R3: A phase's score is the number of window positions equal to the matching `code` bit, from 0 to 31. It is taken on the window as it stands after the shift.
- R4: `wake_pulse` is high for exactly the one cycle after a clock edge at which some enabled phase shifted and its new score was greater than or equal to `threshold`. With no strobe, there is no pulse.
- R5: `irq` goes high in the cycle after a `wake_pulse` and stays high until cleared.
- R6: `win_phase[p]` is set one cycle after phase p fires. Bits from several detections accumulate, and `win_phase` is cleared together with `irq`.
- R7: `irq_clear` high at a clock edge clears `irq` and `win_phase`. If a pulse is present in that same cycle, the new detection wins: `irq` stays set and `win_phase` shows only the new phases.
- R8: While `enable` is low, both windows are held at all zeros and no pulse occurs, whatever the strobes do. `irq` and `win_phase` keep their values.
- R9: After reset, `wake_pulse`, `irq` and `win_phase` are 0 and both windows are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Correlator enable; low clears the windows |
| env_bit | input | 1 | Comparator output of the envelope detector |
| phase_strobe | input | 2 | One-cycle sample strobes, bit 0 for the rising and bit 1 for the falling symbol edge |
| code | input | 31 | Reference code, bit 30 is the first chip |
| threshold | input | 5 | Minimum agreement count for a detection |
| irq_clear | input | 1 | Write-one clear of the interrupt and the phase status |
| wake_pulse | output | 1 | One-cycle detection pulse |
| irq | output | 1 | Sticky wakeup interrupt |
| win_phase | output | 2 | Phases that fired since the last clear |

## Verification
The assertions check these properties on every cycle:
- a window is zero after any disabled cycle and holds when its strobe is idle;
- a detection only follows an enabled strobe;
- a pulse always sets the interrupt and the matching phase bit;
- the interrupt persists until cleared.

The score itself can only be shown by the bench's scenarios. These are: a full code walked into each phase, a threshold sweep over every value from 0 to 31, simultaneous strobes, and a clear colliding with a fresh detection. Each one compares the pulse against an arithmetic count of matching chips.

// File: rtl/wc_pkg.sv
package wc_pkg;
   // Bits needed to hold an agreement count from 0 to n.
   function automatic int score_width(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/wc_agree_count.sv
module wc_agree_count #(
   parameter int N = 31,
   parameter int W = wc_pkg::score_width(N)
) (
   input  logic [N-1:0] window,
   input  logic [N-1:0] ref_code,
   output logic [W-1:0] score
);
   always_comb begin
      score = '0;
      for (int i = 0; i < N; i++) begin
         score = score + W'(window[i] == ref_code[i]);
      end
   end
endmodule

// File: rtl/wc_phase_lane.sv
module wc_phase_lane #(
   parameter int N = 31,
   parameter int W = wc_pkg::score_width(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enable,
   input  logic         strobe,
   input  logic         env_bit,
   input  logic [N-1:0] ref_code,
   input  logic [W-1:0] threshold,
   output logic         hit
);
   logic [N-1:0] win_q, win_d;
   logic [W-1:0] score_d;
   logic         hit_q;

   // Next window: cleared when disabled, shifted on own strobe only.
   always_comb begin
      if (!enable)      win_d = '0;
      else if (strobe)  win_d = {win_q[N-2:0], env_bit};
      else              win_d = win_q;
   end

   wc_agree_count #(.N(N), .W(W)) u_count (
      .window   (win_d),
      .ref_code (ref_code),
      .score    (score_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         hit_q <= 1'b0;
      end else begin
         win_q <= win_d;
         hit_q <= enable && strobe && (score_d >= threshold);
      end
   end

   assign hit = hit_q;

   assert_clear_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (win_q == '0));
   assert_hold_without_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !strobe) |=> $stable(win_q));
   assert_hit_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |-> $past(enable && strobe));
endmodule

// File: rtl/wc_irq_ctrl.sv
module wc_irq_ctrl #(
   parameter int P = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [P-1:0] hits,
   input  logic         clear,
   output logic         irq,
   output logic [P-1:0] won
);
   logic         irq_q;
   logic [P-1:0] won_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         won_q <= '0;
      end else if (clear) begin
         irq_q <= |hits;
         won_q <= hits;
      end else begin
         irq_q <= irq_q | (|hits);
         won_q <= won_q | hits;
      end
   end

   assign irq = irq_q;
   assign won = won_q;

   assert_pulse_sets_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|hits) |=> irq_q);
   assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clear) |=> irq_q);
   assert_cleared_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && hits == '0) |=> (!irq_q && won_q == '0));

   for (genvar p = 0; p < P; p++) begin : g_won_chk
      assert_phase_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
         hits[p] |=> won_q[p]);
   end
endmodule

// File: rtl/wake_corr_top.sv
module wake_corr_top #(
   parameter int  CODE_LEN   = 31,
   parameter int  NUM_PHASES = 2,
   localparam int SCORE_W    = wc_pkg::score_width(CODE_LEN)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic                  env_bit,
   input  logic [NUM_PHASES-1:0] phase_strobe,
   input  logic [CODE_LEN-1:0]   code,
   input  logic [SCORE_W-1:0]    threshold,
   input  logic                  irq_clear,
   output logic                  wake_pulse,
   output logic                  irq,
   output logic [NUM_PHASES-1:0] win_phase
);
   if (CODE_LEN < 2) begin : g_bad_len
      $error("wake_corr_top: CODE_LEN must be at least 2");
   end
   if (NUM_PHASES < 1) begin : g_bad_ph
      $error("wake_corr_top: NUM_PHASES must be at least 1");
   end

   logic [NUM_PHASES-1:0] lane_hit;

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_lane
      wc_phase_lane #(.N(CODE_LEN), .W(SCORE_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .enable    (enable),
         .strobe    (phase_strobe[p]),
         .env_bit   (env_bit),
         .ref_code  (code),
         .threshold (threshold),
         .hit       (lane_hit[p])
      );
   end

   assign wake_pulse = |lane_hit;

   wc_irq_ctrl #(.P(NUM_PHASES)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .hits  (lane_hit),
      .clear (irq_clear),
      .irq   (irq),
      .won   (win_phase)
   );

   assert_no_pulse_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !wake_pulse);
endmodule

// File: tb/sim_wake_corr_top.sv
module sim_wake_corr_top;
   localparam int N = 31;
   localparam int W = 5;
   localparam int P = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n, enable, env_bit, irq_clear;
   logic [P-1:0] phase_strobe;
   logic [N-1:0] code;
   logic [W-1:0] threshold;
   logic         wake_pulse, irq;
   logic [P-1:0] win_phase;

   wake_corr_top u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .env_bit(env_bit),
      .phase_strobe(phase_strobe), .code(code), .threshold(threshold),
      .irq_clear(irq_clear), .wake_pulse(wake_pulse), .irq(irq),
      .win_phase(win_phase)
   );

   int n_chk = 0;
   int n_err = 0;
   logic [N-1:0] m_win [P];
   logic         m_irq;
   logic [P-1:0] m_won;
   logic [15:0]  rng = 16'hACE1;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic rbit(output logic b);
      rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
      b = rng[0];
   endtask

   function automatic int agree(input logic [N-1:0] a, input logic [N-1:0] c);
      int s = 0;
      for (int i = 0; i < N; i++) if (a[i] == c[i]) s++;
      return s;
   endfunction

   // One strobe cycle followed by one idle cycle (clr applied in the idle cycle).
   task automatic step(input logic [P-1:0] stb, input logic b, input logic clr,
                       input string req);
      logic [P-1:0] hits;
      @(negedge clk);
      phase_strobe = stb;
      env_bit = b;
      hits = '0;
      for (int p = 0; p < P; p++) begin
         if (!enable) m_win[p] = '0;
         else if (stb[p]) begin
            m_win[p] = {m_win[p][N-2:0], b};
            if (agree(m_win[p], code) >= int'(threshold)) hits[p] = 1'b1;
         end
      end
      @(negedge clk);
      check(req, "wake_pulse", 32'(wake_pulse), 32'(|hits));
      phase_strobe = '0;
      irq_clear = clr;
      if (clr) begin
         m_irq = |hits;
         m_won = hits;
      end else begin
         m_irq = m_irq | (|hits);
         m_won = m_won | hits;
      end
      @(negedge clk);
      irq_clear = 1'b0;
      check("R5", "irq", 32'(irq), 32'(m_irq));
      check("R6", "win_phase", 32'(win_phase), 32'(m_won));
      check("R4", "pulse one cycle", 32'(wake_pulse), 32'(0));
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      logic b;
      rst_n = 1'b0; enable = 1'b0; env_bit = 1'b0; irq_clear = 1'b0;
      phase_strobe = '0; code = 31'h5A3C96E1; threshold = 5'd31;
      for (int p = 0; p < P; p++) m_win[p] = '0;
      m_irq = 1'b0; m_won = '0;
      repeat (3) @(negedge clk);
      check("R9", "wake_pulse", 32'(wake_pulse), 0);
      check("R9", "irq", 32'(irq), 0);
      check("R9", "win_phase", 32'(win_phase), 0);
      rst_n = 1'b1;
      enable = 1'b1;

      // R2/R3: code walked into phase 0, first chip = code[30]
      for (int i = 0; i < 5; i++) begin rbit(b); step(2'b01, b, 1'b0, "R3"); end
      for (int i = N - 1; i >= 0; i--) step(2'b01, code[i], 1'b0, "R2");
      check("R6", "phase0 fired", 32'(win_phase), 32'h1);
      step(2'b00, 1'b0, 1'b1, "R7");
      check("R7", "irq cleared", 32'(irq), 0);

      // R1: phase 1 gets the code, phase 0 interleaved random chips
      for (int i = N - 1; i >= 0; i--) begin
         rbit(b);
         step(2'b01, b, 1'b0, "R1");
         step(2'b10, code[i], 1'b0, "R1");
      end
      check("R6", "phase1 fired", 32'(win_phase[1]), 32'h1);
      step(2'b00, 1'b0, 1'b1, "R7");

      // R1: both phases shifting in the same cycle
      threshold = 5'd20;
      for (int i = 0; i < 40; i++) begin rbit(b); step(2'b11, b, 1'b0, "R1"); end
      step(2'b00, 1'b0, 1'b1, "R7");

      // R3/R4: threshold sweep with random strobes and chips
      for (int t = 0; t < 32; t++) begin
         logic s0, s1;
         threshold = 5'(t);
         for (int i = 0; i < 12; i++) begin
            rbit(s0); rbit(s1); rbit(b);
            step({s1, s0}, b, (i == 0), "R3");
         end
      end

      // R4: no strobe, no pulse even at threshold 0
      threshold = 5'd0;
      step(2'b00, 1'b0, 1'b1, "R7");
      for (int i = 0; i < 4; i++) begin rbit(b); step(2'b00, b, 1'b0, "R4"); end

      // R7: clear collides with a fresh detection
      step(2'b10, 1'b1, 1'b1, "R7");
      check("R7", "set wins", 32'(irq), 32'h1);

      // R8: disabled ignores strobes, keeps irq, clears windows
      threshold = 5'd0;
      enable = 1'b0;
      for (int i = 0; i < 6; i++) begin rbit(b); step(2'b11, b, 1'b0, "R8"); end
      check("R8", "irq kept", 32'(irq), 32'h1);
      enable = 1'b1;
      threshold = 5'd31;
      step(2'b00, 1'b0, 1'b1, "R7");
      for (int i = 0; i < N; i++) step(2'b01, ~code[N-1-i] ^ (i >= 5), 1'b0, "R8");
      for (int i = N - 1; i >= 0; i--) step(2'b11, code[i], 1'b0, "R8");
      check("R6", "both fired", 32'(win_phase), 32'h3);

      finish_run();
   end
endmodule